// File: doc/BRIEF.md
# ADC Result Threshold Persistence Detector

This block sits behind an ADC conversion pipeline and watches each conversion result as it arrives on a valid/ready stream. It takes the magnitude of every result, interpreted as either unsigned or two's complement, and compares that magnitude with a programmable threshold. An 8-bit event counter goes up on each result at or above the threshold. On each result below the threshold the counter either steps down or drops to zero, depending on the configured mode.

When the counter lands on a programmable limit, a sticky alarm flag is set. The flag drives an interrupt through an enable gate. Because the counter can step down or clear, the alarm marks a sustained excursion rather than a single noisy sample.

Alongside the detector, a 32-bit running sum of all accepted results is kept. Its update is signalled by a one-cycle ready pulse. Software reaches the threshold, limit, counter, sum and flag through plain write strobes and read outputs. The input stream never applies back-pressure: `s_ready` is held high, and a result is consumed on every cycle in which `s_valid` is high.

Top module: `adc_persist_det`

## Requirements
- R1: After reset the threshold reads 0x0000, the limit reads 0x01, and the counter, the sum, the flag, the interrupt and the ready pulse all read 0.
- R2: In unsigned coding (`cfg_twos`=0), a result counts as an event when all 16 bits of the result, as an unsigned value, are greater than or equal to all 16 threshold bits.
- R3: In two's complement coding (`cfg_twos`=1), bits 14:0 of the result's absolute value are compared with threshold bits 14:0, and threshold bit 15 is ignored. The code 0x8000 is given magnitude 0x7FFF.
- R4: Each event raises the counter by one, saturating at 0xFF.
- R5: `cfg_cmp_mode` selects the counting mode. With 2'b01, a below-threshold result lowers the counter by one, saturating at 0. With 2'b10, a below-threshold result clears the counter to 0.
- R6: With `cfg_cmp_mode` at 2'b00 or 2'b11, accepted results leave the counter and the flag unchanged.
- R7: The flag is set at the same clock edge on which the counter takes a value equal to the limit. It stays set until a `flag_clr` pulse. If a set and a clear fall on the same edge, the set wins.
- R8: `irq` is high exactly when the flag is set and `irq_en` is high.
- R9: While `cfg_acc_en` is high, each accepted result is added to the sum modulo 2^32. The result is sign-extended in two's complement coding and zero-extended in unsigned coding. While `cfg_acc_en` is low, the sum reads 0.
- R10: A `reconfig` pulse clears both the counter and the sum at the next edge.
- R11: `acc_ready` is high for exactly the one cycle that follows an edge at which a result was added to the sum.
- R12: `s_ready` is always high, and cycles with `s_valid` low change neither the counter nor the sum.
- R13: A write strobe loads the threshold (`wr_thresh`) or the limit (`wr_limit`) at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Result stream valid |
| s_ready | output | 1 | Result stream ready (always high) |
| s_data | input | 16 | Conversion result |
| cfg_twos | input | 1 | 1 = two's complement coding, 0 = unsigned |
| cfg_cmp_mode | input | 2 | 00 off, 01 decrement below, 10 clear below, 11 off |
| cfg_acc_en | input | 1 | Sum enable; low holds the sum at zero |
| reconfig | input | 1 | Pulse: clear counter and sum |
| wr_thresh | input | 1 | Threshold write strobe |
| wr_thresh_data | input | 16 | Threshold write value |
| wr_limit | input | 1 | Limit write strobe |
| wr_limit_data | input | 8 | Limit write value |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt enable |
| thresh_q | output | 16 | Threshold readback |
| limit_q | output | 8 | Limit readback |
| count_q | output | 8 | Event counter readback |
| acc_q | output | 32 | Running sum readback |
| flag_q | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt |
| acc_ready | output | 1 | One-cycle pulse after each sum update |

## Verification
Unsigned results that sit exactly on, just above and just below the threshold show whether the comparison is inclusive and whether it uses all 16 bits. Negative two's complement results, together with the 0x8000 code and a threshold whose bit 15 is set, show whether the absolute value is taken and whether the comparison is narrowed to 15 bits. Alternating above/below sequences show the decrement mode apart from the clear mode. Runs of several hundred events, and below-threshold results at a zero count, show saturation apart from wrap-around. A negative result added to an empty sum shows whether sign extension and modulo wrap are applied.

// File: rtl/adc_persist_pkg.sv
`timescale 1ns/1ps
package adc_persist_pkg;
  typedef enum logic [1:0] {
    CMP_OFF = 2'b00,
    CMP_DEC = 2'b01,
    CMP_CLR = 2'b10,
    CMP_RSV = 2'b11
  } cmp_mode_e;

  function automatic logic mode_counts(input logic [1:0] m);
    return (m == CMP_DEC) || (m == CMP_CLR);
  endfunction
endpackage

// File: rtl/adc_mag_cmp.sv
`timescale 1ns/1ps
module adc_mag_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] thresh,
  input  logic              twos,
  output logic              at_or_above
);
  localparam int MAG_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [DATA_W-1:0] negated;
  logic [MAG_W-1:0]  mag;

  always_comb begin
    negated = ~data + 1'b1;
    if (data == MOST_NEG) begin
      mag = {MAG_W{1'b1}};
    end else if (data[DATA_W-1]) begin
      mag = negated[MAG_W-1:0];
    end else begin
      mag = data[MAG_W-1:0];
    end
    if (twos) begin
      at_or_above = (mag >= thresh[MAG_W-1:0]);
    end else begin
      at_or_above = (data >= thresh);
    end
  end
endmodule

// File: rtl/adc_evt_counter.sv
`timescale 1ns/1ps
module adc_evt_counter #(
  parameter int              CNT_W     = 8,
  parameter logic [CNT_W-1:0] LIMIT_RST = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             above,
  input  logic             clr_mode,
  input  logic             reconfig,
  input  logic             wr_limit,
  input  logic [CNT_W-1:0] limit_din,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] limit_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] count_nxt;
  logic             hit;

  always_comb begin
    count_nxt = count_q;
    if (above) begin
      if (count_q != CNT_MAX) count_nxt = count_q + 1'b1;
    end else if (clr_mode) begin
      count_nxt = CNT_ZERO;
    end else if (count_q != CNT_ZERO) begin
      count_nxt = count_q - 1'b1;
    end
    hit = step && !reconfig && (count_nxt == limit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_ZERO;
    end else if (reconfig) begin
      count_q <= CNT_ZERO;
    end else if (step) begin
      count_q <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= LIMIT_RST;
    end else if (wr_limit) begin
      limit_q <= limit_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_accum.sv
`timescale 1ns/1ps
module adc_accum #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  input  logic              twos,
  input  logic              acc_en,
  input  logic              reconfig,
  output logic [ACC_W-1:0]  acc_q,
  output logic              ready
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] addend;

  always_comb begin
    if (twos) addend = {{EXT_W{data[DATA_W-1]}}, data};
    else      addend = {{EXT_W{1'b0}}, data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ready <= 1'b0;
    end else begin
      ready <= take && acc_en && !reconfig;
      if (!acc_en || reconfig) begin
        acc_q <= '0;
      end else if (take) begin
        acc_q <= acc_q + addend;
      end
    end
  end
endmodule

// File: rtl/adc_persist_det.sv
`timescale 1ns/1ps
module adc_persist_det #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              cfg_twos,
  input  logic [1:0]        cfg_cmp_mode,
  input  logic              cfg_acc_en,
  input  logic              reconfig,
  input  logic              wr_thresh,
  input  logic [DATA_W-1:0] wr_thresh_data,
  input  logic              wr_limit,
  input  logic [CNT_W-1:0]  wr_limit_data,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic [DATA_W-1:0] thresh_q,
  output logic [CNT_W-1:0]  limit_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic              flag_q,
  output logic              irq,
  output logic              acc_ready
);
  import adc_persist_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT_DEFAULT = 1;

  logic accept;
  logic above;
  logic step;
  logic clr_mode;

  assign s_ready  = 1'b1;
  assign accept   = s_valid && s_ready;
  assign step     = accept && mode_counts(cfg_cmp_mode);
  assign clr_mode = (cfg_cmp_mode == CMP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
    end else if (wr_thresh) begin
      thresh_q <= wr_thresh_data;
    end
  end

  adc_mag_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data        (s_data),
    .thresh      (thresh_q),
    .twos        (cfg_twos),
    .at_or_above (above)
  );

  adc_evt_counter #(.CNT_W(CNT_W), .LIMIT_RST(LIMIT_DEFAULT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .above     (above),
    .clr_mode  (clr_mode),
    .reconfig  (reconfig),
    .wr_limit  (wr_limit),
    .limit_din (wr_limit_data),
    .flag_clr  (flag_clr),
    .count_q   (count_q),
    .limit_q   (limit_q),
    .flag_q    (flag_q)
  );

  adc_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .data     (s_data),
    .twos     (cfg_twos),
    .acc_en   (cfg_acc_en),
    .reconfig (reconfig),
    .acc_q    (acc_q),
    .ready    (acc_ready)
  );

  assign irq = flag_q && irq_en;
endmodule

// File: rtl/adc_persist_det_chk.sv
`timescale 1ns/1ps
module adc_persist_det_chk #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic [1:0]       cfg_cmp_mode,
  input logic             cfg_acc_en,
  input logic             reconfig,
  input logic             flag_clr,
  input logic             irq_en,
  input logic [CNT_W-1:0] count_q,
  input logic [ACC_W-1:0] acc_q,
  input logic             flag_q,
  input logic             irq,
  input logic             acc_ready
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CMAX_M1 = CMAX - 1'b1;

  a_r4_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CMAX) |=> (count_q == CMAX || count_q == CMAX_M1 || count_q == '0));

  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |=> (count_q <= 1));

  a_r6_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_cmp_mode == 2'b00 || cfg_cmp_mode == 2'b11) && !reconfig) |=> $stable(count_q));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && irq_en));

  a_r9_sum_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_acc_en |=> (acc_q == '0));

  a_r10_reconfig_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |=> (count_q == '0 && acc_q == '0));

  a_r11_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> $past(s_valid && cfg_acc_en && !reconfig));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !reconfig && cfg_acc_en) |=> ($stable(count_q) && $stable(acc_q)));

  a_r12_ready_high: assert property (@(posedge clk) disable iff (!rst_n) s_ready);
endmodule

bind adc_persist_det adc_persist_det_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .cfg_cmp_mode (cfg_cmp_mode),
  .cfg_acc_en   (cfg_acc_en),
  .reconfig     (reconfig),
  .flag_clr     (flag_clr),
  .irq_en       (irq_en),
  .count_q      (count_q),
  .acc_q        (acc_q),
  .flag_q       (flag_q),
  .irq          (irq),
  .acc_ready    (acc_ready)
);

// File: tb/adc_persist_det_bench.sv
`timescale 1ns/1ps
module adc_persist_det_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        cfg_twos = 1'b0;
  logic [1:0]  cfg_cmp_mode = 2'b01;
  logic        cfg_acc_en = 1'b1;
  logic        reconfig = 1'b0;
  logic        wr_thresh = 1'b0;
  logic [15:0] wr_thresh_data = '0;
  logic        wr_limit = 1'b0;
  logic [7:0]  wr_limit_data = '0;
  logic        flag_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] thresh_q;
  logic [7:0]  limit_q;
  logic [7:0]  count_q;
  logic [31:0] acc_q;
  logic        flag_q;
  logic        irq;
  logic        acc_ready;

  always #2 clk = ~clk;

  adc_persist_det u_adc_persist_det (.*);

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]  cnt;
    logic        flag;
    logic [31:0] acc;
    logic        rdy;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0]  m_cnt = 0;
  logic        m_flag = 0;
  logic [31:0] m_acc = 0;
  logic [15:0] m_th = 0;
  logic [7:0]  m_lim = 8'h01;
  bit pending = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_above(input logic [15:0] d);
    logic [15:0] a;
    if (!cfg_twos) return d >= m_th;
    if (d == 16'h8000) a = 16'h7FFF;
    else if (d[15]) a = -d;
    else a = d;
    return a[14:0] >= m_th[14:0];
  endfunction

  task automatic send(input logic [15:0] d, input string tag);
    exp_t e;
    if (cfg_cmp_mode == 2'b01 || cfg_cmp_mode == 2'b10) begin
      if (is_above(d)) begin
        if (m_cnt != 8'hFF) m_cnt++;
      end else if (cfg_cmp_mode == 2'b10) m_cnt = 0;
      else if (m_cnt != 0) m_cnt--;
      if (m_cnt == m_lim) m_flag = 1;
    end
    if (cfg_acc_en) m_acc = m_acc + (cfg_twos ? {{16{d[15]}}, d} : {16'h0, d});
    else m_acc = 0;
    e.cnt = m_cnt; e.flag = m_flag; e.acc = m_acc; e.rdy = cfg_acc_en; e.tag = tag;
    q.push_back(e);
    @(negedge clk); s_valid = 1; s_data = d;
    @(negedge clk); s_valid = 0;
  endtask

  task automatic pulse_thresh(input logic [15:0] v);
    @(negedge clk); wr_thresh = 1; wr_thresh_data = v;
    @(negedge clk); wr_thresh = 0; m_th = v;
  endtask

  task automatic pulse_limit(input logic [7:0] v);
    @(negedge clk); wr_limit = 1; wr_limit_data = v;
    @(negedge clk); wr_limit = 0; m_lim = v;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; m_flag = 0;
  endtask

  task automatic pulse_reconfig();
    @(negedge clk); reconfig = 1;
    @(negedge clk); reconfig = 0; m_cnt = 0; m_acc = 0;
  endtask

  // scoreboard monitor
  always @(posedge clk) if (s_valid && s_ready) pending <= 1;
  always @(negedge clk) begin
    if (pending) begin
      exp_t e;
      pending <= 0;
      if (q.size() == 0) begin
        chk(0, "R12 unexpected accept", 0, 0);
      end else begin
        e = q.pop_front();
        chk(count_q == e.cnt, {e.tag, " count"}, count_q, e.cnt);
        chk(flag_q == e.flag, {e.tag, " R7 flag"}, flag_q, e.flag);
        chk(acc_q == e.acc, {e.tag, " R9 sum"}, acc_q, e.acc);
        chk(acc_ready == e.rdy, {e.tag, " R11 ready"}, acc_ready, e.rdy);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(thresh_q == 16'h0, "R1 thresh", thresh_q, 0);
    chk(limit_q == 8'h01, "R1 limit", limit_q, 1);
    chk(count_q == 0, "R1 count", count_q, 0);
    chk(acc_q == 0, "R1 sum", acc_q, 0);
    chk(!flag_q && !irq && !acc_ready, "R1 flag/irq/ready", {flag_q, irq, acc_ready}, 0);
    chk(s_ready, "R12 ready high", s_ready, 1);

    // R2, R5 decrement, R13 writes, R7, R8
    pulse_thresh(16'h9000);
    pulse_limit(8'h03);
    chk(thresh_q == 16'h9000, "R13 thresh write", thresh_q, 16'h9000);
    chk(limit_q == 8'h03, "R13 limit write", limit_q, 3);
    irq_en = 1;
    send(16'h9000, "R2 equal");
    send(16'hFFFF, "R2 top");
    send(16'h8FFF, "R5 dec below");
    send(16'h9001, "R2 above");
    send(16'hA000, "R7 reach limit");
    @(negedge clk);
    chk(irq == 1, "R8 irq on", irq, 1);
    irq_en = 0;
    #0;
    chk(irq == 0, "R8 irq masked", irq, 0);
    send(16'h0000, "R7 sticky after below");
    pulse_clr();
    chk(flag_q == 0, "R7 clear", flag_q, 0);

    // R12 idle cycles ignored
    @(negedge clk); s_data = 16'hFFFF;
    repeat (4) @(negedge clk);
    chk(count_q == m_cnt, "R12 idle count", count_q, m_cnt);
    chk(acc_q == m_acc, "R12 idle sum", acc_q, m_acc);
    chk(acc_ready == 0, "R11 no pulse idle", acc_ready, 0);

    // R3 two's complement magnitude, R10
    pulse_reconfig();
    chk(count_q == 0 && acc_q == 0, "R10 reconfig", {count_q, acc_q[23:0]}, 0);
    cfg_twos = 1;
    pulse_limit(8'h50);
    pulse_thresh(16'h8100);
    send(16'hFF00, "R3 neg at thr");
    send(16'h00FF, "R3 pos below");
    send(16'hFF01, "R3 neg below");
    send(16'h0100, "R3 pos equal");
    pulse_thresh(16'h7FFF);
    send(16'h8000, "R3 most negative");
    send(16'h8001, "R3 near most negative");
    send(16'h7FFE, "R3 just below full");

    // R5 clear mode
    cfg_cmp_mode = 2'b10;
    cfg_twos = 0;
    pulse_thresh(16'h0010);
    send(16'h0020, "R5 clr up");
    send(16'h0030, "R5 clr up2");
    send(16'h000F, "R5 clear below");

    // R6 modes off
    send(16'h0040, "R5 clr up3");
    cfg_cmp_mode = 2'b00;
    send(16'h0040, "R6 off above");
    send(16'h0001, "R6 off below");
    cfg_cmp_mode = 2'b11;
    send(16'h0040, "R6 reserved above");
    send(16'h0001, "R6 reserved below");

    // R4 saturation, R7 flag at 0xFF
    pulse_reconfig();
    pulse_clr();
    cfg_cmp_mode = 2'b01;
    pulse_limit(8'hFF);
    for (int i = 0; i < 262; i++) send(16'h0100, "R4 saturate");
    chk(count_q == 8'hFF, "R4 held at max", count_q, 8'hFF);
    pulse_reconfig();
    send(16'h0001, "R5 dec at zero");
    send(16'h0002, "R5 dec at zero 2");

    // R9 sign extension and wrap, disable
    pulse_reconfig();
    cfg_twos = 1;
    send(16'hFFFF, "R9 minus one");
    send(16'h0003, "R9 wrap");
    cfg_acc_en = 0;
    send(16'h1234, "R9 disabled");
    cfg_acc_en = 1;
    cfg_twos = 0;
    send(16'h8000, "R9 unsigned zero ext");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12 scoreboard drained", q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule